// File: doc/BRIEF.md
# Pulse-Latched Interrupt Status Register

This block captures short active-low pulses on an external line, such as the once-per-revolution index mark of a disk drive, into a sticky status bit. A processor reads that bit through a byte-wide register. Each read clears every latched status bit. An interrupt mask, set and cleared through the same register, decides whether a latched event also drives an active-low interrupt request toward a downstream interrupt controller.

All state changes happen only on cycles where a slow peripheral clock enable is high. The enable is derived from the system clock, which runs every register. The pulse input passes through a two-flop synchronizer on the system clock, and its falling edge is sampled only on enable cycles. The interrupt request is registered once more on the enable. Software polling the register therefore sees a new event one enable step earlier than the interrupt controller does.

Top module: `pulse_irq_reg`

## Requirements
- R1: After reset the status bits and the mask are zero, `rd_data` reads 0x00 and `irq_n` is high.
- R2: A high-to-low transition of `flag_n`, seen after two system-clock synchronizer stages and sampled on an enable cycle, sets status bit 4. With only this source pending and its mask bit clear, `rd_data` reads 0x10.
- R3: Status bit 4 is sticky. It stays set after `flag_n` returns high. While `flag_n` stays low it is not set again.
- R4: A read (`rd_stb` high on an enable cycle) clears all status bits at that enable edge.
- R5: If a falling edge is detected on the same enable cycle as a clearing read, status bit 4 remains set.
- R6: `irq_n` goes low one enable cycle after status bit 4 and mask bit 4 are both 1. The status bit is therefore readable before the request is asserted. With mask bit 4 at 0, `irq_n` stays high.
- R7: Bit 7 of `rd_data` is the OR over all status bits that are set and enabled in the mask.
- R8: A write (`wr_stb` high on an enable cycle) with `wr_data[7]`=1 sets the mask bits selected by 1s in `wr_data[4:0]`. With `wr_data[7]`=0 it clears them. Mask bits not selected are unchanged.
- R9: `irq_n` returns high at the enable edge of a clearing read. If a coincident edge kept the status set, `irq_n` falls again one enable later.
- R10: `rd_stb` and `wr_stb` have no effect on cycles where `pclk_en` is low.
- R11: `rd_data` bits 6..5 read as zero, and status bits 3..0 never set, since the pulse line is the only source present.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pclk_en | input | 1 | Peripheral clock enable, one system-clock cycle wide |
| flag_n | input | 1 | Asynchronous active-low pulse line |
| rd_stb | input | 1 | Register read strobe; clears status on an enable cycle |
| wr_stb | input | 1 | Mask write strobe; acts on an enable cycle |
| wr_data | input | 8 | Write data: bit 7 chooses set or clear, bits 4..0 select mask bits |
| rd_data | output | 8 | Read data: bit 7 pending summary, bits 4..0 status |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
On every cycle, the embedded assertions check several rules. A detected edge always leaves the status bit set, even against a read. A read with no edge empties the status. Non-enable cycles freeze both status and mask. A write with bit 7 set leaves the selected mask bits at 1. The request follows the masked status with a one-enable lag and drops after a read. Only the bench scenarios show the cycle-exact path from the asynchronous pulse through the synchronizer to the status bit, the R6 ordering in which the bit is readable while the request is still high, and the single-event-per-fall behaviour while the line is held low. The bench's running behavioural model compared on every clock also covers the exact coincidence of an edge with a read.

// File: rtl/pir_pkg.sv
package pir_pkg;
   localparam int unsigned REG_W    = 8;
   localparam int unsigned SUM_BIT  = 7;   // pending summary on read
   localparam int unsigned OP_BIT   = 7;   // set(1)/clear(0) select on write
   localparam int unsigned MAX_SRC  = 7;

   typedef struct packed {
      logic             rd;
      logic             wr;
      logic [REG_W-1:0] wdata;
   } pir_bus_t;
endpackage

// File: rtl/pir_edge_sense.sv
module pir_edge_sense #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic pin_n,
   output logic fell
);
   localparam int unsigned LAST = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("pir_edge_sense: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] chain_q;
   logic                   prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[0] <= 1'b1;
      else        chain_q[0] <= pin_n;
   end

   for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q[s] <= 1'b1;
         else        chain_q[s] <= chain_q[s-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    prev_q <= 1'b1;
      else if (tick) prev_q <= chain_q[LAST];
   end

   assign fell = tick & prev_q & ~chain_q[LAST];

   // R3: a line held low cannot produce two detections in a row of enables
   a_r3_single_fall: assert property (@(posedge clk) disable iff (!rst_n)
      fell |=> !prev_q);
endmodule

// File: rtl/pir_status_bank.sv
module pir_status_bank
   import pir_pkg::*;
#(
   parameter int unsigned NUM_SRC  = 5,
   parameter int unsigned FLAG_BIT = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               fell,
   input  pir_bus_t           bus,
   output logic [NUM_SRC-1:0] status,
   output logic [NUM_SRC-1:0] mask
);
   if (FLAG_BIT >= NUM_SRC) begin : g_bad_flag
      $error("pir_status_bank: FLAG_BIT outside the status field");
   end

   logic [NUM_SRC-1:0] status_q, mask_q, set_vec, sel;
   logic               rd_go, wr_go;
   logic               unused_bits;

   assign rd_go       = tick & bus.rd;
   assign wr_go       = tick & bus.wr;
   assign sel         = bus.wdata[NUM_SRC-1:0];
   assign unused_bits = ^bus.wdata;

   for (genvar b = 0; b < NUM_SRC; b++) begin : g_src
      if (b == FLAG_BIT) begin : g_flag
         assign set_vec[b] = fell;
      end else begin : g_absent
         assign set_vec[b] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
      end else if (tick) begin
         status_q <= set_vec | (status_q & {NUM_SRC{~rd_go}});
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
      end else if (wr_go) begin
         if (bus.wdata[OP_BIT]) mask_q <= mask_q | sel;
         else                   mask_q <= mask_q & ~sel;
      end
   end

   assign status = status_q;
   assign mask   = mask_q;

   a_r5_edge_beats_read: assert property (@(posedge clk) disable iff (!rst_n)
      fell |=> status_q[FLAG_BIT]);

   a_r4_read_empties: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && bus.rd && !fell) |=> (status_q == '0));

   a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> ($stable(status_q) && $stable(mask_q)));

   a_r8_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && bus.wr && bus.wdata[OP_BIT]) |=>
         ((mask_q & $past(sel)) == $past(sel)));

   a_r11_only_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q & ~(NUM_SRC'(1) << FLAG_BIT)) == '0);
endmodule

// File: rtl/pir_irq_drive.sv
module pir_irq_drive #(
   parameter int unsigned NUM_SRC = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               rd_clr,
   input  logic [NUM_SRC-1:0] status,
   input  logic [NUM_SRC-1:0] mask,
   output logic               irq_n
);
   logic irq_q;
   logic live;

   assign live = |(status & mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    irq_q <= 1'b0;
      else if (tick) irq_q <= live & ~rd_clr;
   end

   assign irq_n = ~irq_q;

   a_r6_raise_late: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !rd_clr && live) |=> !irq_n);

   a_r6_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !live) |=> irq_n);

   a_r9_drop_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && rd_clr) |=> irq_n);
endmodule

// File: rtl/pulse_irq_reg.sv
module pulse_irq_reg
   import pir_pkg::*;
#(
   parameter int unsigned NUM_SRC     = 5,
   parameter int unsigned FLAG_BIT    = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pclk_en,
   input  logic             flag_n,
   input  logic             rd_stb,
   input  logic             wr_stb,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data,
   output logic             irq_n
);
   localparam logic [REG_W-1:0] LIVE_BITS =
      REG_W'((1 << NUM_SRC) - 1) | REG_W'(1 << SUM_BIT);

   if (NUM_SRC < 1 || NUM_SRC > MAX_SRC) begin : g_bad_width
      $error("pulse_irq_reg: NUM_SRC must be within 1..7");
   end
   if (FLAG_BIT >= NUM_SRC) begin : g_bad_flag
      $error("pulse_irq_reg: FLAG_BIT must be below NUM_SRC");
   end

   logic               fell;
   logic [NUM_SRC-1:0] status, mask;
   pir_bus_t           bus;

   assign bus.rd    = rd_stb;
   assign bus.wr    = wr_stb;
   assign bus.wdata = wr_data;

   pir_edge_sense #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (pclk_en),
      .pin_n (flag_n),
      .fell  (fell)
   );

   pir_status_bank #(.NUM_SRC(NUM_SRC), .FLAG_BIT(FLAG_BIT)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (pclk_en),
      .fell   (fell),
      .bus    (bus),
      .status (status),
      .mask   (mask)
   );

   pir_irq_drive #(.NUM_SRC(NUM_SRC)) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (pclk_en),
      .rd_clr (rd_stb),
      .status (status),
      .mask   (mask),
      .irq_n  (irq_n)
   );

   always_comb begin
      rd_data                = '0;
      rd_data[NUM_SRC-1:0]   = status;
      rd_data[SUM_BIT]       = |(status & mask);
   end

   a_r11_quiet_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data & ~LIVE_BITS) == '0);

   a_r7_summary_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (pclk_en && !rd_stb && rd_data[SUM_BIT]) |=> !irq_n);
endmodule

// File: tb/pulse_irq_reg_test.sv
module pulse_irq_reg_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pclk_en = 1'b0;
   logic       flag_n = 1'b1;
   logic       rd_stb = 1'b0;
   logic       wr_stb = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic       irq_n;

   int total = 0;
   int bad   = 0;
   int cnt   = 0;
   bit done  = 1'b0;

   // behavioural reference state
   bit       m_s1 = 1, m_s2 = 1, m_prev = 1, m_irq = 0;
   bit [4:0] m_stat = '0, m_mask = '0;

   always #10 clk = ~clk;

   pulse_irq_reg uut (
      .clk(clk), .rst_n(rst_n), .pclk_en(pclk_en), .flag_n(flag_n),
      .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_data(wr_data),
      .rd_data(rd_data), .irq_n(irq_n)
   );

   always @(posedge clk or negedge rst_n) begin
      bit       fell, nirq;
      bit [4:0] keep;
      if (!rst_n) begin
         m_s1 = 1; m_s2 = 1; m_prev = 1; m_irq = 0; m_stat = '0; m_mask = '0;
      end else begin
         if (pclk_en) begin
            fell = m_prev && !m_s2;
            keep = rd_stb ? 5'b0 : m_stat;
            nirq = |(keep & m_mask);
            if (wr_stb) begin
               if (wr_data[7]) m_mask = m_mask | wr_data[4:0];
               else            m_mask = m_mask & ~wr_data[4:0];
            end
            m_prev = m_s2;
            m_stat = keep | (fell ? 5'b10000 : 5'b0);
            m_irq  = nirq;
         end
         m_s2 = m_s1;
         m_s1 = flag_n;
      end
   end

   task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cyc(bit rd, bit wr, logic [7:0] d);
      @(negedge clk);
      chk("R2 R7 rd_data vs model", rd_data, {|(m_stat & m_mask), 2'b00, m_stat});
      chk("R6 irq_n vs model", {7'd0, irq_n}, {7'd0, !m_irq});
      cnt     = (cnt + 1) % 4;
      pclk_en = (cnt == 0);
      rd_stb  = rd;
      wr_stb  = wr;
      wr_data = d;
   endtask

   task automatic en_cyc(bit rd, bit wr, logic [7:0] d);
      while (((cnt + 1) % 4) != 0) cyc(0, 0, 8'h00);
      cyc(rd, wr, d);
   endtask

   task automatic noen_cyc(bit rd, bit wr, logic [7:0] d);
      if (((cnt + 1) % 4) == 0) cyc(0, 0, 8'h00);
      cyc(rd, wr, d);
   endtask

   task automatic look();
      @(posedge clk);
      #1;
   endtask

   task automatic pulse(int len);
      flag_n = 1'b0;
      repeat (len) cyc(0, 0, 8'h00);
      flag_n = 1'b1;
      repeat (8) cyc(0, 0, 8'h00);
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) cyc(0, 0, 8'h00);
      rst_n = 1'b1;
      cyc(0, 0, 8'h00);
      look();
      chk("R1 reset rd_data", rd_data, 8'h00);
      chk("R1 reset irq_n", {7'd0, irq_n}, 8'h01);

      pulse(8);
      look();
      chk("R2 pulse latched", rd_data, 8'h10);
      chk("R6 masked irq_n stays high", {7'd0, irq_n}, 8'h01);
      repeat (12) cyc(0, 0, 8'h00);
      look();
      chk("R3 sticky after release", rd_data, 8'h10);

      en_cyc(1, 0, 8'h00);
      look();
      chk("R4 read clears", rd_data, 8'h00);

      // held low: one event only
      flag_n = 1'b0;
      repeat (10) cyc(0, 0, 8'h00);
      look();
      chk("R2 held-low fall", rd_data, 8'h10);
      en_cyc(1, 0, 8'h00);
      repeat (20) cyc(0, 0, 8'h00);
      look();
      chk("R3 no re-set while low", rd_data, 8'h00);
      flag_n = 1'b1;
      repeat (8) cyc(0, 0, 8'h00);

      // strobes without enable
      pulse(8);
      noen_cyc(1, 0, 8'h00);
      look();
      chk("R10 read without enable", rd_data, 8'h10);
      noen_cyc(0, 1, 8'h90);
      look();
      chk("R10 write without enable", rd_data, 8'h10);

      // mask writes
      en_cyc(0, 1, 8'h90);
      look();
      chk("R7 summary bit", rd_data, 8'h90);
      chk("R6 irq lags one enable", {7'd0, irq_n}, 8'h01);
      en_cyc(0, 0, 8'h00);
      look();
      chk("R6 irq asserted", {7'd0, irq_n}, 8'h00);
      en_cyc(0, 1, 8'h01);
      look();
      chk("R8 unselected bit kept", rd_data, 8'h90);
      en_cyc(0, 1, 8'h10);
      look();
      chk("R8 clear selected", rd_data, 8'h10);
      en_cyc(0, 0, 8'h00);
      look();
      chk("R6 irq off when masked", {7'd0, irq_n}, 8'h01);
      en_cyc(0, 1, 8'h83);
      look();
      chk("R8 other bits set only", rd_data, 8'h10);
      chk("R11 absent sources", rd_data & 8'h6F, 8'h00);
      en_cyc(0, 1, 8'h90);
      en_cyc(0, 0, 8'h00);
      look();
      chk("R6 irq with mask", {7'd0, irq_n}, 8'h00);

      en_cyc(1, 0, 8'h00);
      look();
      chk("R9 irq drops on read", {7'd0, irq_n}, 8'h01);
      chk("R4 read clears again", rd_data, 8'h00);

      // readable before the request
      flag_n = 1'b0;
      for (int i = 0; i < 40; i++) begin
         cyc(0, 0, 8'h00);
         look();
         if (rd_data[4]) break;
      end
      chk("R6 status visible first", rd_data, 8'h90);
      chk("R6 irq still high at set", {7'd0, irq_n}, 8'h01);
      flag_n = 1'b1;
      en_cyc(0, 0, 8'h00);
      look();
      chk("R6 irq follows", {7'd0, irq_n}, 8'h00);
      repeat (8) cyc(0, 0, 8'h00);

      // edge coincident with clearing read
      while (cnt != 1) cyc(0, 0, 8'h00);
      cyc(0, 0, 8'h00);
      flag_n = 1'b0;
      cyc(0, 0, 8'h00);
      cyc(1, 0, 8'h00);
      look();
      chk("R5 edge survives read", rd_data, 8'h90);
      chk("R9 irq drops on read", {7'd0, irq_n}, 8'h01);
      en_cyc(0, 0, 8'h00);
      look();
      chk("R9 irq returns", {7'd0, irq_n}, 8'h00);
      flag_n = 1'b1;
      repeat (12) cyc(0, 0, 8'h00);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule